// File: doc/BRIEF.md
# Eight-bit subtract instruction executor

This block carries out the two subtract operations of a small accumulator-based controller core. One takes an eight-bit immediate and subtracts the working register from it. The other subtracts the working register from a byte in banked data memory, and an instruction bit sends the difference either back to the working register or to the memory byte. The block keeps the working register and a five-flag status register. The carry flag is the inverse of the borrow.

An instruction word is taken together with a valid strobe and a 4-bit bank value. The block then steps through a four-phase instruction cycle: decode, operand read, compute, destination write. The data memory is 4096 bytes and sits outside the block. It is reached through an address bus, a read enable with combinational read data, and a write enable with write data. Any word that matches neither encoding runs the same four phases and changes nothing.

Top module: `subtract_exec`

## Requirements
- R1: A word whose upper byte is 0x08 computes (low byte − W) and puts the difference in W.
- R2: A word whose upper six bits are 010111 uses bit 9 as destination select, bit 8 as bank mode and bits 7:0 as file address. It computes (memory byte − W). With bit 9 at 0 the difference goes to W and memory is not written.
- R3: With bit 9 at 1 the difference is written to the addressed memory byte and W keeps its value.
- R4: With bit 8 at 0 the bank input is ignored. File addresses 0x00–0x7F reach physical 0x000–0x07F and 0x80–0xFF reach 0xF80–0xFFF.
- R5: With bit 8 at 1 the physical address is {bank input, file address}.
- R6: Status bit 0 (C) is 1 when no borrow occurs and 0 on a borrow. Status bit 2 (Z) is 1 when the 8-bit difference is zero.
- R7: Status bit 4 (N) is difference bit 7. Status bit 3 (OV) is 1 when the operand signs differ and the difference's sign differs from the minuend's sign.
- R8: Status bit 1 (DC) is 1 when no borrow passes from bit 3 into bit 4.
- R9: `done` is high for exactly one cycle, the fourth after acceptance. W, status and memory change only at the edge that ends that cycle.
- R10: `instr_valid` is ignored while an instruction is in progress.
- R11: Any other word completes its four phases and changes neither W, status nor memory.
- R12: After reset W = 0, status = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word valid |
| instr_word | input | 16 | Instruction word |
| bank_sel | input | 4 | Bank select value |
| mem_addr | output | 12 | Data memory physical address |
| mem_rd_en | output | 1 | Operand read enable |
| mem_rdata | input | 8 | Data memory read data (combinational) |
| mem_wr_en | output | 1 | Data memory write enable |
| mem_wdata | output | 8 | Data memory write data |
| w_out | output | 8 | Working register |
| status_out | output | 5 | Flags {N, OV, Z, DC, C} |
| done | output | 1 | Instruction completes this cycle |

## Verification
The immediate form is driven with operand pairs that give a positive, a zero and a negative difference. This separates C from Z and N. Signed-overflow pairs in both directions, and pairs with and without a low-nibble borrow, isolate OV and DC from C. The memory form is driven with both destinations, with low and high access addresses, and with a bank value that must be ignored and one that must be applied. Neighbouring bytes are preloaded with sentinel values, so a write to a wrong address shows up. Near-miss opcodes and a word offered during a busy cycle show that nothing leaks through.

// File: rtl/subx_pkg.sv
package subx_pkg;
    localparam int DATA_W = 8;
    localparam int BANK_W = 4;
    localparam int ADDR_W = DATA_W + BANK_W;
    localparam int WORD_W = 16;

    localparam logic [7:0] LIT_OPC = 8'h08;
    localparam logic [5:0] REG_OPC = 6'b010111;

    typedef enum logic [1:0] {PH_Q1, PH_Q2, PH_Q3, PH_Q4} phase_e;
    typedef enum logic [1:0] {OP_NONE, OP_LIT, OP_REG} op_e;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;
endpackage

// File: rtl/subx_decode.sv
module subx_decode
    import subx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [BANK_W-1:0] bank,
    output op_e               op,
    output logic              to_mem,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [DATA_W-1:0] literal
);
    localparam logic [BANK_W-1:0] BANK_LO = '0;
    localparam logic [BANK_W-1:0] BANK_HI = '1;

    logic [DATA_W-1:0] fadr;
    logic              banked;

    always_comb begin
        fadr    = word[DATA_W-1:0];
        literal = word[DATA_W-1:0];
        banked  = word[8];
        to_mem  = word[9];
        if (word[15:8] == LIT_OPC)
            op = OP_LIT;
        else if (word[15:10] == REG_OPC)
            op = OP_REG;
        else
            op = OP_NONE;
        if (banked)
            phys_addr = {bank, fadr};
        else if (fadr[DATA_W-1])
            phys_addr = {BANK_HI, fadr};
        else
            phys_addr = {BANK_LO, fadr};
    end

    // R4: access mode only reaches the lowest or highest bank
    always_comb begin
        if (!banked) begin
            p_access_bank_r4: assert (phys_addr[ADDR_W-1:DATA_W] == BANK_LO ||
                                      phys_addr[ADDR_W-1:DATA_W] == BANK_HI);
        end
    end
endmodule

// File: rtl/subx_alu.sv
module subx_alu
    import subx_pkg::*;
(
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    output logic [DATA_W-1:0] diff,
    output flags_t            flags
);
    logic [DATA_W:0] full;
    logic [4:0]      low;

    always_comb begin
        full     = {1'b0, minuend} - {1'b0, subtrahend};
        low      = {1'b0, minuend[3:0]} - {1'b0, subtrahend[3:0]};
        diff     = full[DATA_W-1:0];
        flags.c  = ~full[DATA_W];
        flags.dc = ~low[4];
        flags.z  = (diff == '0);
        flags.n  = diff[DATA_W-1];
        flags.ov = (minuend[DATA_W-1] ^ subtrahend[DATA_W-1]) &
                   (diff[DATA_W-1] ^ minuend[DATA_W-1]);
    end

    // R6: a zero difference can never come with a borrow
    always_comb begin
        if (flags.z) begin
            p_zero_no_borrow_r6: assert (flags.c);
        end
    end
endmodule

// File: rtl/subtract_exec.sv
module subtract_exec
    import subx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [WORD_W-1:0]     instr_word,
    input  logic [BANK_W-1:0]     bank_sel,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_rd_en,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  mem_wr_en,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W-1:0]     w_out,
    output logic [4:0]            status_out,
    output logic                  done
);
    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic              to_mem;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] operand;
        logic [DATA_W-1:0] result;
        flags_t            flags;
        logic [DATA_W-1:0] w;
        flags_t            status;
    } state_t;

    state_t s_d, s_q;

    op_e               dec_op;
    logic              dec_to_mem;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_lit;
    logic [DATA_W-1:0] alu_diff;
    flags_t            alu_flags;

    subx_decode u_decode (
        .word      (instr_word),
        .bank      (bank_sel),
        .op        (dec_op),
        .to_mem    (dec_to_mem),
        .phys_addr (dec_addr),
        .literal   (dec_lit)
    );

    subx_alu u_alu (
        .minuend    (s_q.operand),
        .subtrahend (s_q.w),
        .diff       (alu_diff),
        .flags      (alu_flags)
    );

    always_comb begin
        s_d       = s_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        case (s_q.phase)
            PH_Q1: begin
                if (instr_valid) begin
                    s_d.op      = dec_op;
                    s_d.to_mem  = dec_to_mem;
                    s_d.addr    = dec_addr;
                    s_d.operand = dec_lit;
                    s_d.phase   = PH_Q2;
                end
            end
            PH_Q2: begin
                if (s_q.op == OP_REG) begin
                    mem_rd_en   = 1'b1;
                    s_d.operand = mem_rdata;
                end
                s_d.phase = PH_Q3;
            end
            PH_Q3: begin
                s_d.result = alu_diff;
                s_d.flags  = alu_flags;
                s_d.phase  = PH_Q4;
            end
            default: begin
                if (s_q.op != OP_NONE) begin
                    s_d.status = s_q.flags;
                    if (s_q.op == OP_REG && s_q.to_mem)
                        mem_wr_en = 1'b1;
                    else
                        s_d.w = s_q.result;
                end
                s_d.phase = PH_Q1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign mem_addr   = s_q.addr;
    assign mem_wdata  = s_q.result;
    assign w_out      = s_q.w;
    assign status_out = s_q.status;
    assign done       = (s_q.phase == PH_Q4);

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: architectural state only moves on the edge closing a done cycle
    p_w_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(w_out));
    p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(status_out));
    // R3: memory writes happen only in the write phase
    p_write_in_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> done);
    // R3: a write-back is preceded by the operand read two cycles earlier
    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2));
endmodule

// File: tb/subtract_exec_bench.sv
module subtract_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [3:0]  bank_sel = '0;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  w_out;
    logic [4:0]  status_out;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] mem [4096];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr];

    subtract_exec u_subtract_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .bank_sel    (bank_sel),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rdata   (mem_rdata),
        .mem_wr_en   (mem_wr_en),
        .mem_wdata   (mem_wdata),
        .w_out       (w_out),
        .status_out  (status_out),
        .done        (done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    // Runs one instruction; optionally offers another word while busy (R10)
    task automatic run(input logic [15:0] word, input logic [3:0] bsr, input bit inject);
        logic [7:0] w0;
        logic [4:0] s0;
        w0 = w_out;
        s0 = status_out;
        instr_word  = word;
        bank_sel    = bsr;
        instr_valid = 1'b1;
        @(negedge clk);
        if (inject) instr_word = 16'h08AA;
        else        instr_valid = 1'b0;
        chk("R9 done low in phase 2", int'(done), 0);
        chk("R9 W held in phase 2", int'(w_out), int'(w0));
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R9 status held in phase 3", int'(status_out), int'(s0));
        @(negedge clk);
        chk("R9 done in phase 4", int'(done), 1);
        @(negedge clk);
        chk("R9 done drops", int'(done), 0);
    endtask

    task automatic setw(input logic [7:0] v);
        run({8'h08, v + w_out}, 4'h0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R12 W after reset", int'(w_out), 0);
        chk("R12 status after reset", int'(status_out), 0);
        chk("R12 done after reset", int'(done), 0);
    endtask

    task automatic t_literal();
        setw(8'h01);
        run(16'h0802, 4'h0, 1'b0);
        chk("R1 2-1 result", int'(w_out), 8'h01);
        chk("R6 2-1 status", int'(status_out), 5'b00011);
        setw(8'h02);
        run(16'h0802, 4'h0, 1'b0);
        chk("R6 2-2 result", int'(w_out), 8'h00);
        chk("R6 2-2 status zero", int'(status_out), 5'b00111);
        setw(8'h03);
        run(16'h0802, 4'h0, 1'b0);
        chk("R6 2-3 result", int'(w_out), 8'hFF);
        chk("R6 2-3 status borrow", int'(status_out), 5'b10000);
    endtask

    task automatic t_overflow_dc();
        setw(8'h01);
        run(16'h0880, 4'h0, 1'b0);
        chk("R7 80-01 result", int'(w_out), 8'h7F);
        chk("R7 80-01 status", int'(status_out), 5'b01001);
        setw(8'hFF);
        run(16'h087F, 4'h0, 1'b0);
        chk("R7 7F-FF result", int'(w_out), 8'h80);
        chk("R7 7F-FF status", int'(status_out), 5'b11010);
        setw(8'h01);
        run(16'h081F, 4'h0, 1'b0);
        chk("R8 1F-01 status", int'(status_out), 5'b00011);
        setw(8'h01);
        run(16'h0810, 4'h0, 1'b0);
        chk("R8 10-01 result", int'(w_out), 8'h0F);
        chk("R8 10-01 status", int'(status_out), 5'b00001);
    endtask

    task automatic t_reg_to_w();
        mem[12'h020] = 8'h03;
        setw(8'h02);
        run(16'h5C20, 4'h3, 1'b0);
        chk("R2 reg to W result", int'(w_out), 8'h01);
        chk("R2 reg to W status", int'(status_out), 5'b00011);
        chk("R2 memory untouched", int'(mem[12'h020]), 8'h03);
        mem[12'hF00] = 8'h09;
        setw(8'h04);
        run(16'h5D00, 4'hF, 1'b0);
        chk("R5 banked read to W", int'(w_out), 8'h05);
    endtask

    task automatic t_reg_to_mem();
        mem[12'hF90] = 8'h10;
        mem[12'h090] = 8'h55;
        mem[12'hA90] = 8'h66;
        setw(8'h20);
        run(16'h5E90, 4'hA, 1'b0);
        chk("R3 write-back value", int'(mem[12'hF90]), 8'hF0);
        chk("R3 W kept", int'(w_out), 8'h20);
        chk("R3 status", int'(status_out), 5'b10010);
        chk("R4 low bank untouched", int'(mem[12'h090]), 8'h55);
        chk("R4 bank input ignored", int'(mem[12'hA90]), 8'h66);
        mem[12'h07F] = 8'h05;
        mem[12'hA7F] = 8'h77;
        setw(8'h05);
        run(16'h5E7F, 4'hA, 1'b0);
        chk("R4 low access write", int'(mem[12'h07F]), 8'h00);
        chk("R4 banked copy untouched", int'(mem[12'hA7F]), 8'h77);
        chk("R6 mem zero status", int'(status_out), 5'b00111);
        mem[12'h534] = 8'h40;
        mem[12'h034] = 8'h99;
        setw(8'h01);
        run(16'h5F34, 4'h5, 1'b0);
        chk("R5 banked write", int'(mem[12'h534]), 8'h3F);
        chk("R5 access copy untouched", int'(mem[12'h034]), 8'h99);
        chk("R5 banked status", int'(status_out), 5'b00001);
    endtask

    task automatic t_noop();
        logic [7:0] w0;
        logic [4:0] s0;
        mem[12'h0FF] = 8'h12;
        mem[12'hFFF] = 8'h34;
        setw(8'h3C);
        w0 = w_out;
        s0 = status_out;
        run(16'hFFFF, 4'h0, 1'b0);
        run(16'h0900, 4'h0, 1'b0);
        run(16'h5BFF, 4'h0, 1'b0);
        chk("R11 W unchanged", int'(w_out), int'(w0));
        chk("R11 status unchanged", int'(status_out), int'(s0));
        chk("R11 memory 0FF unchanged", int'(mem[12'h0FF]), 8'h12);
        chk("R11 memory FFF unchanged", int'(mem[12'hFFF]), 8'h34);
    endtask

    task automatic t_busy();
        setw(8'h10);
        run(16'h0830, 4'h0, 1'b1);
        chk("R10 first word result", int'(w_out), 8'h20);
        @(negedge clk);
        chk("R10 no second done", int'(done), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 still no done", int'(done), 0);
        chk("R10 W unchanged", int'(w_out), 8'h20);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_literal();
        t_overflow_dc();
        t_reg_to_w();
        t_reg_to_mem();
        t_noop();
        t_busy();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule